// File: doc/BRIEF.md
# Offset-Encoded PLL Divider Pair

This block holds the two programmable counters that fix the ratio of a frequency-synthesis loop. The reference divider turns the reference clock into a train of comparison pulses. The feedback divider turns the oscillator clock into a second pulse train, which runs at the same nominal rate once the loop has settled. The phase detector that compares the two trains, the charge pump and the oscillator are not part of this block.

Each ratio comes from a static configuration word with a fixed offset. The reference path divides by `ref_word + 2`. The feedback path divides by `2*(fb_word + 5)`, so the synthesized frequency is Fref * 2(fb_word+5)/(ref_word+2). The feedback path is built as a divide-by-(fb_word+5) counter followed by a toggle stage. This makes its divided clock an exact 50% square wave.

A configuration word is sampled only at the end of a full output period, so a period in progress always completes at its old length. Each domain has its own flag. The flag reports whether the word now on the input is the one that sets the current period. It depends only on the counter state and does not wait for loop lock.

Top module: `pllc_divider_pair`

## Requirements
- R1: With the reference word held at Q (REF_W bits, unsigned), consecutive `ref_pulse` assertions are exactly Q+2 `ref_clk` cycles apart.
- R2: With the feedback word held at P (FB_W bits, unsigned), consecutive `fb_pulse` assertions are exactly 2*(P+5) `vco_clk` cycles apart.
- R3: `fb_half_clk` is high for P+5 cycles and low for P+5 cycles of each feedback period. `fb_pulse` is asserted in the first cycle in which `fb_half_clk` is low again after its high half.
- R4: `ref_pulse` and `fb_pulse` are each high for exactly one cycle of their own clock per period.
- R5: Each synchronous active-high reset (`ref_rst`, `vco_rst`) holds that domain's pulse, valid flag and half clock at 0 and clears its counter. The first reference pulse is visible after the (Q+2)-th `ref_clk` rising edge following reset release. The first feedback pulse is visible after the 2(P+5)-th `vco_clk` rising edge.
- R6: A change of a configuration word has no effect on the period in progress. That period ends at its old length, and the new ratio applies from the period that starts with the next pulse.
- R7: A valid flag is 0 out of reset. It becomes 1 in the cycle its pulse is asserted, with the word sampled at that edge. It returns to 0 one cycle after its word input differs from the sampled word, unless that edge ends a period.
- R8: The extreme words are handled: Q=0 gives a period of 2, Q=2^REF_W-1 gives 2^REF_W+1, P=0 gives 10, and P=2^FB_W-1 gives 2*(2^FB_W+4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| ref_rst | input | 1 | Synchronous active-high reset, reference domain |
| ref_word | input | REF_W | Reference configuration word Q (ratio Q+2) |
| ref_pulse | output | 1 | One-cycle comparison pulse per reference period |
| ref_valid | output | 1 | Reference ratio in effect matches `ref_word` |
| vco_clk | input | 1 | Oscillator clock |
| vco_rst | input | 1 | Synchronous active-high reset, oscillator domain |
| fb_word | input | FB_W | Feedback configuration word P (ratio 2*(P+5)) |
| fb_pulse | output | 1 | One-cycle pulse per feedback period |
| fb_half_clk | output | 1 | 50% duty divided feedback clock |
| fb_valid | output | 1 | Feedback ratio in effect matches `fb_word` |

## Verification
The bench builds the block with REF_W=4 and FB_W=5. This brings every reference word and every feedback word within an exhaustive sweep, including both extremes, while keeping each period under a hundred cycles. For each word the bench checks four things against ratios computed from the offset formulas: the latency from reset to the first pulse, the spacing of later pulses, the pulse width and the high time of the half clock. In a separate run in each domain the word is changed in the middle of a period. The bench then checks the old spacing once, the new spacing after that, and the fall and rise of the valid flag.

// File: rtl/pllc_pkg.sv
`timescale 1ns/1ps
package pllc_pkg;

    // Fixed encodings of the two configuration words
    localparam int REF_OFFSET = 2;   // reference ratio = word + 2
    localparam int FB_OFFSET  = 5;   // feedback half ratio = word + 5

    // Counter width needed for terminal value (2**w - 1) + off - 1
    function automatic int cnt_width(input int w, input int off);
        return $clog2((1 << w) + off - 1);
    endfunction

endpackage

// File: rtl/pllc_offset_div.sv
`timescale 1ns/1ps
module pllc_offset_div #(
    parameter int WORD_W = 10,
    parameter int OFFSET = 2,
    parameter bit HALVE  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_i,
    output logic              pulse_o,
    output logic              half_o,
    output logic              valid_o
);

    localparam int CW = pllc_pkg::cnt_width(WORD_W, OFFSET);

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic [WORD_W-1:0] ratio;
        logic              half;
        logic              pulse;
        logic              valid;
    } div_state_t;

    div_state_t st_q, st_d;

    logic [CW-1:0] term;
    logic          wrap;
    logic          period_end;
    logic          half_nxt;

    assign term = CW'(st_q.ratio) + CW'(OFFSET - 1);
    assign wrap = (st_q.cnt == term);

    generate
        if (HALVE) begin : g_halve
            // Two counter wraps make one output period
            assign period_end = wrap & st_q.half;
            assign half_nxt   = wrap ? ~st_q.half : st_q.half;
        end else begin : g_plain
            assign period_end = wrap;
            assign half_nxt   = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.cnt   = wrap ? '0 : st_q.cnt + 1'b1;
        st_d.half  = half_nxt;
        st_d.pulse = period_end;
        if (period_end) begin
            st_d.ratio = word_i;
            st_d.valid = 1'b1;
        end else if (word_i != st_q.ratio) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt   <= '0;
            st_q.ratio <= word_i;
            st_q.half  <= 1'b0;
            st_q.pulse <= 1'b0;
            st_q.valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;
    assign half_o  = st_q.half;
    assign valid_o = st_q.valid;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= term); // R1

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        st_q.pulse |=> !st_q.pulse); // R4

    AST_RATIO_HELD: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> $stable(st_q.ratio)); // R6

    AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
        (st_q.valid && (word_i != st_q.ratio) && !period_end) |=> !st_q.valid); // R7

    generate
        if (HALVE) begin : g_half_chk
            AST_PULSE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
                st_q.pulse |-> (!st_q.half && $past(st_q.half))); // R3
        end
    endgenerate

endmodule

// File: rtl/pllc_divider_pair.sv
`timescale 1ns/1ps
module pllc_divider_pair #(
    parameter int REF_W = 10,
    parameter int FB_W  = 12
) (
    input  logic             ref_clk,
    input  logic             ref_rst,
    input  logic [REF_W-1:0] ref_word,
    output logic             ref_pulse,
    output logic             ref_valid,
    input  logic             vco_clk,
    input  logic             vco_rst,
    input  logic [FB_W-1:0]  fb_word,
    output logic             fb_pulse,
    output logic             fb_half_clk,
    output logic             fb_valid
);

    logic ref_half_unused;

    pllc_offset_div #(
        .WORD_W (REF_W),
        .OFFSET (pllc_pkg::REF_OFFSET),
        .HALVE  (1'b0)
    ) u_ref_div (
        .clk     (ref_clk),
        .rst     (ref_rst),
        .word_i  (ref_word),
        .pulse_o (ref_pulse),
        .half_o  (ref_half_unused),
        .valid_o (ref_valid)
    );

    pllc_offset_div #(
        .WORD_W (FB_W),
        .OFFSET (pllc_pkg::FB_OFFSET),
        .HALVE  (1'b1)
    ) u_fb_div (
        .clk     (vco_clk),
        .rst     (vco_rst),
        .word_i  (fb_word),
        .pulse_o (fb_pulse),
        .half_o  (fb_half_clk),
        .valid_o (fb_valid)
    );

endmodule

// File: tb/pllc_divider_pair_tb.sv
`timescale 1ns/1ps
module pllc_divider_pair_tb;

    localparam int RW = 4;
    localparam int FW = 5;

    logic          ref_clk = 1'b0;
    logic          vco_clk = 1'b0;
    logic          ref_rst = 1'b1;
    logic          vco_rst = 1'b1;
    logic [RW-1:0] ref_word = '0;
    logic [FW-1:0] fb_word = '0;
    logic          ref_pulse, ref_valid, fb_pulse, fb_half_clk, fb_valid;

    int nvec = 0;
    int nfail = 0;

    always #5 ref_clk = ~ref_clk;
    always #5 vco_clk = ~vco_clk;

    pllc_divider_pair #(.REF_W(RW), .FB_W(FW)) u_dut (
        .ref_clk     (ref_clk),
        .ref_rst     (ref_rst),
        .ref_word    (ref_word),
        .ref_pulse   (ref_pulse),
        .ref_valid   (ref_valid),
        .vco_clk     (vco_clk),
        .vco_rst     (vco_rst),
        .fb_word     (fb_word),
        .fb_pulse    (fb_pulse),
        .fb_half_clk (fb_half_clk),
        .fb_valid    (fb_valid)
    );

    task automatic chk(input string tag, input int got, input int exp);
        nvec++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic ref_wait(input int start, output int n);
        n = start;
        forever begin
            @(negedge ref_clk);
            n++;
            if (ref_pulse) break;
            if (n > 5000) begin
                chk("R1 no reference pulse", n, -1);
                break;
            end
        end
    endtask

    task automatic fb_wait(input int start, output int n, output int highs);
        n = start;
        highs = 0;
        forever begin
            @(negedge vco_clk);
            n++;
            if (fb_half_clk) highs++;
            if (fb_pulse) break;
            if (n > 5000) begin
                chk("R2 no feedback pulse", n, -1);
                break;
            end
        end
    endtask

    initial begin
        #1ms;
        nfail++;
        $display("FAIL watchdog expired got 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        int n;
        int h;
        // Reference path: every word
        for (int w = 0; w < (1 << RW); w++) begin
            @(negedge ref_clk);
            ref_word = RW'(w);
            ref_rst = 1'b1;
            @(negedge ref_clk);
            @(negedge ref_clk);
            chk("R5 ref_pulse in reset", int'(ref_pulse), 0);
            chk("R5 ref_valid in reset", int'(ref_valid), 0);
            ref_rst = 1'b0;
            ref_wait(0, n);
            chk((w == 0 || w == (1 << RW) - 1) ? "R8 first ref pulse" : "R5 first ref pulse", n, w + 2);
            chk("R7 ref_valid at pulse", int'(ref_valid), 1);
            @(negedge ref_clk);
            chk("R4 ref_pulse width", int'(ref_pulse), 0);
            ref_wait(1, n);
            chk((w == 0 || w == (1 << RW) - 1) ? "R8 ref spacing" : "R1 ref spacing", n, w + 2);
        end
        // Reference word change mid-period
        @(negedge ref_clk);
        ref_word = RW'(5);
        ref_rst = 1'b1;
        @(negedge ref_clk);
        @(negedge ref_clk);
        ref_rst = 1'b0;
        ref_wait(0, n);
        @(negedge ref_clk);
        @(negedge ref_clk);
        ref_word = RW'(9);
        @(negedge ref_clk);
        chk("R7 ref_valid drop", int'(ref_valid), 0);
        ref_wait(3, n);
        chk("R6 ref old period kept", n, 7);
        chk("R7 ref_valid back", int'(ref_valid), 1);
        ref_wait(0, n);
        chk("R6 ref new period", n, 11);

        // Feedback path: every word
        for (int w = 0; w < (1 << FW); w++) begin
            @(negedge vco_clk);
            fb_word = FW'(w);
            vco_rst = 1'b1;
            @(negedge vco_clk);
            @(negedge vco_clk);
            chk("R5 fb_pulse in reset", int'(fb_pulse), 0);
            chk("R5 fb_valid in reset", int'(fb_valid), 0);
            chk("R5 fb_half_clk in reset", int'(fb_half_clk), 0);
            vco_rst = 1'b0;
            fb_wait(0, n, h);
            chk((w == 0 || w == (1 << FW) - 1) ? "R8 first fb pulse" : "R5 first fb pulse", n, 2 * (w + 5));
            chk("R3 fb high time", h, w + 5);
            chk("R3 fb half low at pulse", int'(fb_half_clk), 0);
            chk("R7 fb_valid at pulse", int'(fb_valid), 1);
            @(negedge vco_clk);
            chk("R4 fb_pulse width", int'(fb_pulse), 0);
            fb_wait(1, n, h);
            chk((w == 0 || w == (1 << FW) - 1) ? "R8 fb spacing" : "R2 fb spacing", n, 2 * (w + 5));
            chk("R3 fb high time steady", h, w + 5);
        end
        // Feedback word change mid-period
        @(negedge vco_clk);
        fb_word = FW'(3);
        vco_rst = 1'b1;
        @(negedge vco_clk);
        @(negedge vco_clk);
        vco_rst = 1'b0;
        fb_wait(0, n, h);
        @(negedge vco_clk);
        @(negedge vco_clk);
        fb_word = FW'(10);
        @(negedge vco_clk);
        chk("R7 fb_valid drop", int'(fb_valid), 0);
        fb_wait(3, n, h);
        chk("R6 fb old period kept", n, 16);
        chk("R7 fb_valid back", int'(fb_valid), 1);
        fb_wait(0, n, h);
        chk("R6 fb new period", n, 30);
        chk("R3 fb new high time", h, 15);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule